// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is a down/up counter that advances on a slow reference tick (nominally 32.768 kHz, delivered as a one-cycle strobe `tick_i` in the system clock domain) through a selectable prescaler. As a general-purpose timer it counts in either direction, wraps over its full range or reloads a programmed value, and raises a sticky interrupt on each wrap. As a watchdog it counts down from the load value and must be refreshed before reaching zero. Expiry raises either a sticky reset request or a sticky interrupt. An optional secure refresh accepts only a clear value that matches an internal pseudo-random key.

Software reaches the block through a write-only register port. Address 0 is the control register, address 1 the load value, and address 2 the refresh/clear strobe. Writes to address 3 are ignored. The control register can be read back on `ctrl_o`. A power-down input can freeze the count when software has asked for that behaviour.

Top module: `guard_timer`

## Requirements
- R1: After reset, `count_o`, `ctrl_o`, `irq_o` and `rst_req_o` are all zero. The prescaler code 0 (divide by 1) is therefore the default.
- R2: A write to address 1 stores the low 16 data bits as the load value and copies them into the count in the same cycle.
- R3: Control bit 0 clear selects down counting. Each prescaled step decrements the count. In free-running mode (control bit 2 clear) the count steps from 0 to 0xFFFF.
- R4: Control bit 0 set selects up counting. Each step increments the count. In free-running mode the count steps from 0xFFFF to 0.
- R5: Control bit 2 set selects periodic mode, in which a wrap reloads the load value instead. In timer mode every wrap sets `irq_o`, which stays high until a write to address 2 clears it.
- R6: With control bit 1 (run) clear, the count does not change.
- R7: Control bits 6:5 select a step every 1, 16, 256 or 32768 ticks for codes 0 to 3. Changing the control register restarts the division. Without `tick_i` the count does not advance.
- R8: With control bit 8 set and `pd_i` high, the count is frozen. With bit 8 clear, `pd_i` has no effect.
- R9: Control bits 16:9 are reserved. Whatever is written there, `ctrl_o` returns zero in them.
- R10: Control bit 3 enables watchdog mode. The count then always decrements, whatever bit 0 says. A step taken at a count of 1 or 0 leaves the count at 0. With control bit 7 clear, that step sets `rst_req_o`, which stays high until reset.
- R11: With control bit 7 set, a watchdog expiry sets `irq_o` and leaves `rst_req_o` low.
- R12: In watchdog mode without secure refresh (control bit 4 clear), any write to address 2 reloads the count from the load value and clears `irq_o`.
- R13: With control bit 4 set, a refresh is accepted only if data bits 7:0 equal an 8-bit key. The key is 0xA5 after reset, and each accepted refresh advances it to {k[6:0], k[7]^k[5]^k[4]^k[3]}. A mismatch leaves the key and count as they are and triggers the expiry action at once.
- R14: Once watchdog mode is set, writes to the control register are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe at the reference rate |
| pd_i | input | 1 | Peripheral power-down indication |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 control, 1 load, 2 refresh) |
| wr_data_i | input | 32 | Write data |
| count_o | output | 16 | Current count |
| ctrl_o | output | 17 | Control register readback |
| irq_o | output | 1 | Sticky interrupt request |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The embedded properties check the following on every cycle:
- the reset request stays high once raised;
- the control register stays frozen after watchdog mode locks it;
- the count holds while stopped or frozen by power-down;
- a watchdog resting at zero stays there;
- interrupt-mode expiry never raises a reset;
- the prescaler never fires two steps back to back at a ratio above one;
- the key never reaches zero.

Only the bench scenarios can show the other behaviours:
- the exact step values and wrap targets in each direction and mode;
- the divide ratios;
- the timing of expiry;
- the secure key sequence, including the action taken on a mismatch.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

    // Control register layout, most significant field first (bit 8 down to bit 0)
    typedef struct packed {
        logic       pd_stop;   // freeze while pd_i is high
        logic       irq_sel;   // watchdog expiry raises interrupt instead of reset
        logic [1:0] presc;     // prescaler code
        logic       secure;    // refresh must match key
        logic       wd;        // watchdog mode (locks control)
        logic       periodic;  // reload on wrap
        logic       run;       // counting enabled
        logic       up;        // count direction
    } ctrl_t;

    localparam int CTRL_W     = $bits(ctrl_t);
    localparam int CTRL_REG_W = 17;
    localparam int KEY_W      = 8;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_LOAD = 2'd1,
        A_KICK = 2'd2
    } addr_e;

endpackage

// File: rtl/guard_timer_presc.sv
module guard_timer_presc #(
    parameter int DIV1_LOG = 4,
    parameter int DIV2_LOG = 8,
    parameter int DIV3_LOG = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       run_i,
    input  logic       clr_i,
    input  logic [1:0] sel_i,
    output logic       ce_o
);
    localparam int PW = DIV3_LOG;

    logic [PW-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        case (sel_i)
            2'd1:    limit = {PW{1'b1}} >> (PW - DIV1_LOG);
            2'd2:    limit = {PW{1'b1}} >> (PW - DIV2_LOG);
            2'd3:    limit = {PW{1'b1}};
            default: limit = '0;
        endcase
        ce_o  = tick_i && run_i && !clr_i && (cnt_q == limit);
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (tick_i && run_i)
            cnt_d = (cnt_q == limit) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: above divide-by-1, two steps never fire on consecutive cycles
    p_ce_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_o && sel_i != 2'd0 && !clr_i) |=> !ce_o);

endmodule

// File: rtl/guard_timer_key.sv
module guard_timer_key
    import guard_timer_pkg::*;
#(
    parameter logic [KEY_W-1:0] SEED = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [KEY_W-1:0] key_o
);
    logic [KEY_W-1:0] key_d, key_q;

    always_comb begin
        key_d = key_q;
        if (adv_i)
            key_d = {key_q[KEY_W-2:0], key_q[7] ^ key_q[5] ^ key_q[4] ^ key_q[3]};
        key_o = key_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= SEED;
        else        key_q <= key_d;
    end

    // R13: the key sequence never collapses to the all-zero lock-up state
    p_key_nonzero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        key_q != '0);

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_timer_pkg::*;
#(
    parameter int               CNT_W    = 16,
    parameter int               DATA_W   = 32,
    parameter int               DIV1_LOG = 4,
    parameter int               DIV2_LOG = 8,
    parameter int               DIV3_LOG = 15,
    parameter logic [KEY_W-1:0] KEY_SEED = 8'hA5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  pd_i,
    input  logic                  wr_en_i,
    input  logic [1:0]            wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    output logic [CNT_W-1:0]      count_o,
    output logic [CTRL_REG_W-1:0] ctrl_o,
    output logic                  irq_o,
    output logic                  rst_req_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] count;
        logic             irq;
        logic             rst_req;
    } state_t;

    state_t st_d, st_q;
    logic   run_eff, ce, presc_clr, key_adv, key_ok;
    logic [KEY_W-1:0] key;

    guard_timer_presc #(
        .DIV1_LOG(DIV1_LOG), .DIV2_LOG(DIV2_LOG), .DIV3_LOG(DIV3_LOG)
    ) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_eff),
        .clr_i(presc_clr), .sel_i(st_q.ctrl.presc), .ce_o(ce)
    );

    guard_timer_key #(.SEED(KEY_SEED)) u_key (
        .clk(clk), .rst_n(rst_n), .adv_i(key_adv), .key_o(key)
    );

    always_comb begin
        st_d      = st_q;
        run_eff   = st_q.ctrl.run && !(st_q.ctrl.pd_stop && pd_i);
        key_ok    = (wr_data_i[KEY_W-1:0] == key);
        presc_clr = 1'b0;
        key_adv   = 1'b0;

        if (wr_en_i) begin
            case (wr_addr_i)
                A_CTRL: begin
                    if (!st_q.ctrl.wd) begin
                        st_d.ctrl = ctrl_t'(wr_data_i[CTRL_W-1:0]);
                        presc_clr = 1'b1;
                    end
                end
                A_LOAD: begin
                    st_d.load  = wr_data_i[CNT_W-1:0];
                    st_d.count = wr_data_i[CNT_W-1:0];
                end
                A_KICK: begin
                    if (!st_q.ctrl.wd) begin
                        st_d.irq = 1'b0;
                    end else if (!st_q.ctrl.secure || key_ok) begin
                        st_d.count = st_q.load;
                        st_d.irq   = 1'b0;
                        key_adv    = st_q.ctrl.secure;
                    end else if (st_q.ctrl.irq_sel) begin
                        st_d.irq = 1'b1;
                    end else begin
                        st_d.rst_req = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (ce) begin
            if (st_q.ctrl.wd) begin
                if (st_q.count <= CNT_ONE) begin
                    st_d.count = '0;
                    if (st_q.ctrl.irq_sel) st_d.irq = 1'b1;
                    else                   st_d.rst_req = 1'b1;
                end else begin
                    st_d.count = st_q.count - 1'b1;
                end
            end else if (st_q.ctrl.up) begin
                if (st_q.count == CNT_MAX) begin
                    st_d.count = st_q.ctrl.periodic ? st_q.load : '0;
                    st_d.irq   = 1'b1;
                end else begin
                    st_d.count = st_q.count + 1'b1;
                end
            end else begin
                if (st_q.count == '0) begin
                    st_d.count = st_q.ctrl.periodic ? st_q.load : CNT_MAX;
                    st_d.irq   = 1'b1;
                end else begin
                    st_d.count = st_q.count - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o   = st_q.count;
    assign ctrl_o    = {{(CTRL_REG_W - CTRL_W){1'b0}}, st_q.ctrl};
    assign irq_o     = st_q.irq;
    assign rst_req_o = st_q.rst_req;

    p_rst_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_req |=> st_q.rst_req);

    p_ctrl_lock_r14: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.wd |=> $stable(st_q.ctrl));

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && (!st_q.ctrl.run || (st_q.ctrl.pd_stop && pd_i)))
        |=> $stable(st_q.count));

    p_wd_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.wd && st_q.count == '0 && !wr_en_i) |=> st_q.count == '0);

    p_irq_mode_no_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.wd && st_q.ctrl.irq_sel && !st_q.rst_req) |=> !st_q.rst_req);

endmodule

// File: tb/guard_timer_test.sv
`timescale 1ns/1ps
module guard_timer_test;
    localparam logic [31:0] UP = 32'h1, RUN = 32'h2, PER = 32'h4, WD = 32'h8;
    localparam logic [31:0] SEC = 32'h10, IRQSEL = 32'h80, PDSTOP = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, tick = 1'b1, pd = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] count;
    logic [16:0] ctrl;
    logic        irq, rst_req;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;
    logic [15:0] m, ld;
    logic        mi;
    logic [7:0]  key;

    always #10 clk = ~clk;

    guard_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .pd_i(pd), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .count_o(count), .ctrl_o(ctrl),
        .irq_o(irq), .rst_req_o(rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; pd = 1'b0; tick = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] next_key(input logic [7:0] k);
        return {k[6:0], k[7] ^ k[5] ^ k[4] ^ k[3]};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 count", count, 0); chk("R1 ctrl", ctrl, 0);
        chk("R1 irq", irq, 0);     chk("R1 rst_req", rst_req, 0);

        // R9: reserved control bits read zero
        wr(2'd0, 32'hFFFF_FE00 | RUN);
        chk("R9 reserved", ctrl, RUN);

        // R3/R4/R5/R7: direction x mode x ratio sweep with an arithmetic model
        for (int cfg = 0; cfg < 8; cfg++) begin
            logic up_b, per_b;
            int   div;
            up_b  = cfg[0];
            per_b = cfg[1];
            div   = cfg[2] ? 16 : 1;
            ld    = up_b ? 16'hFFFB : 16'd4;
            do_reset();
            wr(2'd1, {16'h0, ld});
            chk("R2 load", count, ld);
            wr(2'd0, RUN | (up_b ? UP : 0) | (per_b ? PER : 0) | (cfg[2] ? 32'h20 : 0));
            m = ld; mi = 1'b0;
            for (int c = 1; c <= 12 * div; c++) begin
                @(negedge clk);
                if (c % div == 0) begin
                    if (up_b) begin
                        if (m == 16'hFFFF) begin m = per_b ? ld : 16'h0; mi = 1'b1; end
                        else m = m + 1'b1;
                    end else begin
                        if (m == 16'h0) begin m = per_b ? ld : 16'hFFFF; mi = 1'b1; end
                        else m = m - 1'b1;
                    end
                end
                chk(up_b ? (per_b ? "R4 R5 count" : "R4 count") : (per_b ? "R3 R5 count" : "R3 count"),
                    count, m);
                chk(cfg[2] ? "R7 R5 irq" : "R5 irq", irq, mi);
            end
            wr(2'd2, 32'h0);
            chk("R5 irq clear", irq, 0);
        end

        // R7: large ratios 256 and 32768
        for (int ps = 2; ps < 4; ps++) begin
            int div;
            div = (ps == 2) ? 256 : 32768;
            do_reset();
            wr(2'd1, 32'd100);
            wr(2'd0, RUN | (ps << 5));
            for (int c = 1; c <= 2 * div; c++) begin
                @(negedge clk);
                chk("R7 ratio", count, 100 - c / div);
            end
        end

        // R6 run clear, R7 no tick
        do_reset();
        wr(2'd1, 32'd7);
        idle(5);
        chk("R6 stopped", count, 7);
        tick = 1'b0;
        wr(2'd0, RUN);
        idle(5);
        chk("R7 no tick", count, 7);
        tick = 1'b1;
        idle(2);
        chk("R7 tick resumes", count, 5);

        // R8 power-down freeze
        do_reset();
        wr(2'd1, 32'd9);
        pd = 1'b1;
        wr(2'd0, RUN | PDSTOP);
        idle(5);
        chk("R8 frozen", count, 9);
        pd = 1'b0;
        idle(3);
        chk("R8 released", count, 6);
        pd = 1'b1;
        wr(2'd0, RUN);
        idle(2);
        chk("R8 pd ignored", count, 4);

        // R10 watchdog reset expiry, direction bit ignored
        do_reset();
        wr(2'd1, 32'd3);
        wr(2'd0, WD | RUN | UP);
        idle(1); chk("R10 count", count, 2);
        idle(1); chk("R10 count", count, 1); chk("R10 no req yet", rst_req, 0);
        idle(1); chk("R10 count zero", count, 0); chk("R10 rst_req", rst_req, 1);
        chk("R10 irq low", irq, 0);
        idle(3); chk("R10 hold zero", count, 0); chk("R10 rst_req held", rst_req, 1);
        // R14 control locked
        wr(2'd0, RUN);
        chk("R14 lock", ctrl, WD | RUN | UP);

        // R12 plain refresh
        do_reset();
        wr(2'd1, 32'd6);
        wr(2'd0, WD | RUN);
        idle(3);
        chk("R12 before", count, 3);
        wr(2'd2, 32'h1234);
        chk("R12 reload", count, 6);
        idle(2);
        chk("R12 after", count, 4); chk("R12 no reset", rst_req, 0);

        // R11 interrupt expiry, R12 clears it
        do_reset();
        wr(2'd1, 32'd2);
        wr(2'd0, WD | RUN | IRQSEL);
        idle(2);
        chk("R11 count zero", count, 0); chk("R11 irq", irq, 1); chk("R11 no reset", rst_req, 0);
        wr(2'd2, 32'h0);
        chk("R12 irq cleared", irq, 0); chk("R12 reload", count, 2);

        // R13 secure refresh, interrupt action
        do_reset();
        key = 8'hA5;
        wr(2'd1, 32'd20);
        wr(2'd0, WD | RUN | SEC | IRQSEL);
        idle(2);
        wr(2'd2, {24'h0, key});
        chk("R13 accept seed", count, 20); chk("R13 irq", irq, 0);
        key = next_key(key);
        idle(1);
        chk("R13 stepping", count, 19);
        wr(2'd2, {24'h0, key});
        chk("R13 accept next", count, 20);
        key = next_key(key);
        wr(2'd2, {24'h0, key ^ 8'h01});
        chk("R13 mismatch irq", irq, 1); chk("R13 mismatch no reset", rst_req, 0);
        chk("R13 mismatch count kept", count, 20);
        wr(2'd2, {24'h0, key});
        chk("R13 key unchanged by mismatch", irq, 0);
        chk("R13 reload", count, 20);

        // R13 secure refresh, reset action
        do_reset();
        wr(2'd1, 32'd20);
        wr(2'd0, WD | RUN | SEC);
        wr(2'd2, 32'h0000_0000);
        chk("R13 mismatch reset", rst_req, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule